// File: doc/BRIEF.md
# I2C Configuration Register Bank Slave

This block sits on a two-wire I2C bus and holds nine 8-bit configuration registers for an audio signal path. A bus master addresses it, sends a subaddress byte that picks a starting register and says whether the index should advance, and then streams one or more data bytes into the bank. Every byte the block accepts is acknowledged by pulling SDA low during the ninth clock. The register contents are presented in parallel on `regs_o`, register i occupying bits `[8*i+7:8*i]`.

When the master addresses the block for reading, the block returns a status byte made from two live flag inputs, reloading it after every master acknowledge so that status can be polled repeatedly without a new address phase. Both bus lines are oversampled by the system clock through two-flop synchronizers; the system clock must run at least eight times faster than SCL, and the bus may run at up to 500 kbit/s. SDA is driven open-drain: the block only ever asserts a pull-low enable.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register reads 8'hFE and the pull-low enable on SDA is off.
- R2: An address byte whose upper seven bits equal 7'b1000100 is acknowledged on the ninth clock; any other address is not acknowledged and the bytes that follow it until the next START change no register.
- R3: A falling SDA while SCL is high is a START and restarts address reception, also in mid-transaction; a rising SDA while SCL is high is a STOP, after which SDA is released and the block is idle. The block changes its SDA drive only while SCL is low, apart from releasing it on START or STOP.
- R4: The byte after a write address is the subaddress: bits 3..0 pick the register index, bit 4 set enables index advance, bits 7..5 have no effect; it is acknowledged.
- R5: Each data byte, received MSB first, is written to the register at the current index and acknowledged.
- R6: With index advance enabled, each data byte moves the index up by one; once the index is 8 it stays at 8 and later bytes overwrite register 8.
- R7: With index advance disabled, every data byte of the transaction rewrites the same register.
- R8: Data bytes whose index is 9 to 15 are acknowledged but change no register.
- R9: With R/W = 1 the address is acknowledged and the block sends bytes MSB first in which bit 1 is the zero-cross-mute flag, bit 0 the soft-mute flag and bits 7..2 are 0; the byte is re-sampled from the flags after each master acknowledge, and a master non-acknowledge ends the read.
- R10: The register outputs change only in the cycle after a data byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| zc_muted_i | input | 1 | Zero-cross-mute status flag (read bit 1) |
| soft_mute_i | input | 1 | Soft-mute status flag (read bit 0) |
| regs_o | output | 72 | Register bank, register i in bits [8*i+7:8*i] |

## Verification
On every cycle the assertions watch the SDA drive against the bus events: no acknowledge pulse without a completed byte, release after STOP and in idle, no drive for a foreign address, and drive changes only in SCL-low time. They also tie every change of the register outputs to an accepted data byte and follow the index as it steps, holds or saturates. Which register a byte lands in, the MSB-first assembly of the value, the discarding of writes beyond index 8, the repeated-start path and the refresh of the status byte between reads can only be shown by the bench's bus transactions compared against its own register model.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_READ
  } bus_state_e;

  // Next register index after a data byte: advance only when enabled and below the last index
  function automatic logic [IDX_W-1:0] step_index(input logic [IDX_W-1:0] idx,
                                                  input logic             adv,
                                                  input logic [IDX_W-1:0] last);
    if (adv && (idx < last)) return idx + 1'b1;
    return idx;
  endfunction

  // Status byte returned on reads
  function automatic logic [7:0] status_byte(input logic zc, input logic sm);
    return {6'b000000, zc, sm};
  endfunction

  // Bit of an outgoing byte for bit slot pos (slot 0 is the MSB)
  function automatic logic tx_bit(input logic [7:0] b, input logic [IDX_W-1:0] pos);
    return b[3'(4'd7 - pos)];
  endfunction
endpackage

// File: rtl/i2cr_line_sync.sv
`timescale 1ns/1ps
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_ff[STAGES-1];
  assign sda_lvl_o  = sda_ff[STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_prev;
  assign scl_fall_o = ~scl_lvl_o & scl_prev;
  assign start_o    = scl_lvl_o & scl_prev & sda_prev & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_prev & ~sda_prev & sda_lvl_o;
endmodule

// File: rtl/i2cr_regfile.sv
`timescale 1ns/1ps
module i2cr_regfile
  import i2cr_pkg::*;
#(
  parameter int         NREG    = 9,
  parameter logic [7:0] RST_VAL = 8'hFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              r_q <= RST_VAL;
      else if (we_i && (idx_i == IDX_W'(g)))   r_q <= wdata_i;
    end
    assign regs_o[8*g +: 8] = r_q;
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         NREG     = 9,
  parameter logic [7:0] RST_VAL  = 8'hFE,
  parameter int         SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  input  logic              zc_muted_i,
  input  logic              soft_mute_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  // Bus events from the synchronizer
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2cr_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  bus_state_e       state_q;
  logic [3:0]       bit_cnt_q;
  logic             ack_phase_q;
  logic [7:0]       shreg_q;
  logic [7:0]       tx_q;
  logic [IDX_W-1:0] cur_idx_q;
  logic             auto_inc_q;
  logic             sda_low_q;

  // Named internal events (also observed by the checker)
  logic       byte_done, addr_match, wr_en, rd_mode;
  logic [7:0] status;

  assign rd_mode    = (state_q == ST_READ);
  assign byte_done  = scl_fall && !ack_phase_q && (bit_cnt_q == 4'd8) &&
                      ((state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA));
  assign addr_match = (shreg_q[7:1] == DEV_ADDR);
  assign wr_en      = byte_done && (state_q == ST_DATA);
  assign status     = status_byte(zc_muted_i, soft_mute_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      ack_phase_q <= 1'b0;
      shreg_q     <= '0;
      tx_q        <= '0;
      cur_idx_q   <= '0;
      auto_inc_q  <= 1'b0;
      sda_low_q   <= 1'b0;
    end else if (start_det) begin
      state_q     <= ST_ADDR;
      bit_cnt_q   <= '0;
      ack_phase_q <= 1'b0;
      sda_low_q   <= 1'b0;
    end else if (stop_det) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      ack_phase_q <= 1'b0;
      sda_low_q   <= 1'b0;
    end else if (state_q == ST_READ) begin
      if (scl_fall && (ack_phase_q || bit_cnt_q == 4'd9)) begin
        // end of an acknowledge slot: reload the status byte, present its MSB
        ack_phase_q <= 1'b0;
        tx_q        <= status;
        sda_low_q   <= ~status[7];
        bit_cnt_q   <= '0;
      end else if (scl_rise && !ack_phase_q) begin
        if (bit_cnt_q == 4'd8 && sda_lvl) begin
          state_q   <= ST_IDLE;       // master declined further bytes
          sda_low_q <= 1'b0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
      end else if (scl_fall && !ack_phase_q) begin
        if (bit_cnt_q == 4'd8)      sda_low_q <= 1'b0;
        else if (bit_cnt_q != 4'd0) sda_low_q <= ~tx_bit(tx_q, bit_cnt_q);
      end
    end else if (state_q != ST_IDLE) begin
      if (ack_phase_q) begin
        if (scl_fall) begin
          ack_phase_q <= 1'b0;
          sda_low_q   <= 1'b0;
          bit_cnt_q   <= '0;
        end
      end else if (scl_rise && bit_cnt_q < 4'd8) begin
        shreg_q   <= {shreg_q[6:0], sda_lvl};
        bit_cnt_q <= bit_cnt_q + 4'd1;
      end else if (byte_done) begin
        unique case (state_q)
          ST_ADDR: begin
            if (addr_match) begin
              ack_phase_q <= 1'b1;
              sda_low_q   <= 1'b1;
              state_q     <= shreg_q[0] ? ST_READ : ST_SUB;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_SUB: begin
            cur_idx_q   <= shreg_q[IDX_W-1:0];
            auto_inc_q  <= shreg_q[4];
            ack_phase_q <= 1'b1;
            sda_low_q   <= 1'b1;
            state_q     <= ST_DATA;
          end
          default: begin
            cur_idx_q   <= step_index(cur_idx_q, auto_inc_q, LAST_IDX);
            ack_phase_q <= 1'b1;
            sda_low_q   <= 1'b1;
          end
        endcase
      end
    end
  end

  i2cr_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .idx_i(cur_idx_q),
    .wdata_i(shreg_q), .regs_o(regs_o)
  );

  assign sda_drive_low_o = sda_low_q;
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker
  import i2cr_pkg::*;
#(
  parameter int NREG = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_drive_low_o,
  input logic [NREG*8-1:0] regs_o,
  input logic              wr_en,
  input logic              byte_done,
  input logic              addr_match,
  input logic              rd_mode,
  input logic              start_det,
  input logic              stop_det,
  input logic              scl_lvl,
  input bus_state_e        state_q,
  input logic              auto_inc_q,
  input logic [IDX_W-1:0]  cur_idx_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> $past(wr_en)); // R10

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_low_o) && !rd_mode) |-> $past(byte_done)); // R5

  AST_NACK_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == ST_ADDR && !addr_match) |=> !sda_drive_low_o); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_drive_low_o && state_q == ST_IDLE)); // R3

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_drive_low_o); // R3

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive_low_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && auto_inc_q && cur_idx_q < LAST_IDX) |=> (cur_idx_q == $past(cur_idx_q) + 1'b1)); // R6

  AST_IDX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_idx_q >= LAST_IDX) |=> $stable(cur_idx_q)); // R6

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !auto_inc_q) |=> $stable(cur_idx_q)); // R7
endmodule

bind i2c_regbank_slave i2cr_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_drive_low_o(sda_drive_low_o), .regs_o(regs_o),
  .wr_en(wr_en), .byte_done(byte_done), .addr_match(addr_match), .rd_mode(rd_mode),
  .start_det(start_det), .stop_det(stop_det), .scl_lvl(scl_lvl), .state_q(state_q),
  .auto_inc_q(auto_inc_q), .cur_idx_q(cur_idx_q)
);

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb_top;
  localparam int NREG = 9;
  localparam int HP   = 80;   // SCL half period in ns (ten system clocks)

  logic clk = 1'b0;
  always #4 clk = ~clk;       // 125 MHz

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic zc = 1'b0, sm = 1'b0;
  logic sda_low;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_low;

  i2c_regbank_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(sda_low), .zc_muted_i(zc), .soft_mute_i(sm), .regs_o(regs)
  );

  typedef struct { string tag; logic [7:0] v; } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  int n_run = 0, n_fail = 0;
  logic [7:0] model [NREG];
  bit done = 0;

  // Monitor: pops expected/observed pairs and compares
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t e;
        logic [7:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        n_run++;
        if (o !== e.v) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", e.tag, o, e.v);
        end
      end
    end
  end

  task automatic push(input string tag, input logic [7:0] expv, input logic [7:0] obsv);
    exp_q.push_back('{tag, expv});
    obs_q.push_back(obsv);
  endtask

  task automatic bus_start();
    #(HP/2) sda_m = 1'b1;
    #(HP/2) scl_m = 1'b1;
    #HP     sda_m = 1'b0;
    #HP     scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #(HP/2) sda_m = 1'b0;
    #(HP/2) scl_m = 1'b1;
    #HP     sda_m = 1'b1;
    #HP;
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    #(HP/2) sda_m = b;
    #(HP/2) scl_m = 1'b1;
    #(HP/2) seen  = sda_line;
    #(HP/2) scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_line);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, ack_line);
  endtask

  task automatic recv_byte(input logic mack, input logic nzc, input logic nsm, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, b[i]);
    zc = nzc;
    sm = nsm;
    bus_bit(mack, s);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++) push(tag, model[i], regs[8*i +: 8]);
  endtask

  // Full write transaction; the bench model applies the index rules of R4..R8
  task automatic wr_txn(input string tag, input logic [7:0] sub, input logic [7:0] d [4], input int n);
    logic a;
    logic [3:0] idx;
    bit adv;
    idx = sub[3:0];
    adv = sub[4];
    bus_start();
    send_byte(8'h88, a); push({tag, " R2 addr ack"}, 8'h00, {7'b0, a});
    send_byte(sub, a);   push({tag, " R4 sub ack"},  8'h00, {7'b0, a});
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a); push({tag, " R5 data ack"}, 8'h00, {7'b0, a});
      if (idx < 4'(NREG)) model[idx] = d[k];
      if (adv && idx < 4'(NREG - 1)) idx = idx + 4'd1;
    end
    bus_stop();
    push({tag, " R3 released after stop"}, 8'h00, {7'b0, sda_low});
    check_regs(tag);
  endtask

  initial begin
    logic a;
    logic [7:0] rb;
    logic [7:0] d [4];
    for (int i = 0; i < NREG; i++) model[i] = 8'hFE;

    #96 rst_n = 1'b1;
    #HP;
    // R1: reset state
    push("R1 sda released", 8'h00, {7'b0, sda_low});
    check_regs("R1 reset value");

    // R5 single byte to register 0 (MSB-first value with mixed bits)
    d = '{8'h29, 8'h00, 8'h00, 8'h00};
    wr_txn("R5 single", 8'h00, d, 1);

    // R7 no advance, bits 7..5 of subaddress set (R4): both bytes hit register 3
    d = '{8'h39, 8'h12, 8'h00, 8'h00};
    wr_txn("R7 same reg", 8'hE3, d, 2);

    // R6 advance from 5 across 8, saturating at 8
    d = '{8'h22, 8'h33, 8'h44, 8'h55};
    wr_txn("R6 advance", 8'h15, d, 4);
    d = '{8'h61, 8'h62, 8'h00, 8'h00};
    wr_txn("R6 saturate", 8'h18, d, 2);

    // R8 indices 9..15 acknowledged but discarded
    d = '{8'hAB, 8'h00, 8'h00, 8'h00};
    wr_txn("R8 idx 11", 8'h0B, d, 1);
    d = '{8'hC1, 8'hC2, 8'h00, 8'h00};
    wr_txn("R8 idx 14 adv", 8'h1E, d, 2);

    // R2 foreign address: no ack, following bytes ignored
    bus_start();
    send_byte(8'h8A, a); push("R2 foreign addr nack", 8'h01, {7'b0, a});
    send_byte(8'h00, a); push("R2 ignored sub", 8'h01, {7'b0, a});
    send_byte(8'h77, a); push("R2 ignored data", 8'h01, {7'b0, a});
    bus_stop();
    check_regs("R2 unchanged");

    // R3 repeated START restarts the address phase
    bus_start();
    send_byte(8'h88, a); push("R3 addr ack", 8'h00, {7'b0, a});
    send_byte(8'h01, a); push("R3 sub ack", 8'h00, {7'b0, a});
    send_byte(8'h5A, a); push("R3 data ack", 8'h00, {7'b0, a});
    model[1] = 8'h5A;
    bus_start();
    send_byte(8'h88, a); push("R3 readdr ack", 8'h00, {7'b0, a});
    send_byte(8'h02, a); push("R3 resub ack", 8'h00, {7'b0, a});
    send_byte(8'hA5, a); push("R3 redata ack", 8'h00, {7'b0, a});
    model[2] = 8'hA5;
    bus_stop();
    check_regs("R3 repeated start");

    // R9 read: status refreshed after each master ack, nack ends read
    zc = 1'b1; sm = 1'b0;
    bus_start();
    send_byte(8'h89, a); push("R9 read addr ack", 8'h00, {7'b0, a});
    recv_byte(1'b0, 1'b0, 1'b1, rb); push("R9 status zc", 8'h02, rb);
    recv_byte(1'b0, 1'b1, 1'b1, rb); push("R9 status sm", 8'h01, rb);
    recv_byte(1'b1, 1'b0, 1'b0, rb); push("R9 status both", 8'h03, rb);
    bus_stop();
    push("R9 released after read", 8'h00, {7'b0, sda_low});
    check_regs("R10 read leaves regs");

    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule